// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block keeps the modem status register of a 16550-style serial port. It brings the four incoming modem lines (clear-to-send, data-set-ready, carrier detect and ring indicator) into the clock domain, stores their levels, and raises a sticky change flag for each line when its level moves. For the ring indicator, only the end of a ring (a fall) raises the flag.

A read strobe from the bus decoder returns the 8-bit register. In normal mode the read then clears all change flags. When the modem control register selects loopback, the read returns the modem control outputs, mapped onto the status positions, and leaves the stored flags untouched. The block drives an any-change output and a modem status interrupt request, which is gated by the interrupt-enable bit, to the interrupt encoder.

Top module: `modem_status_unit`

## Requirements
- R1: Read data bits 7..4 carry the stored levels of carrier detect, ring indicator, data-set-ready and clear-to-send, in that order from bit 7 down. Bits 3..0 carry their change flags: bit 3 carrier detect changed, bit 2 ring ended, bit 1 data-set-ready changed, bit 0 clear-to-send changed.
- R2: A level change on clear-to-send, data-set-ready or carrier detect sets its change flag. The flag stays set until a normal-mode read clears it. A change on an input pin appears in the register after the third rising clock edge that follows it.
- R3: The ring flag (bit 2) is set when the ring indicator falls from 1 to 0, and is not set when it rises from 0 to 1.
- R4: A read with loopback off returns the register value from before the clock edge, and the edge then clears bits 3..0. If a new change lands on that same edge, its flag is set after the edge.
- R5: With loopback on, a read returns out2 in bit 7, out1 in bit 6, dtr in bit 5 and rts in bit 4, with bits 3..0 zero.
- R6: A read with loopback on does not clear any change flag.
- R7: After reset the register holds 0xB0, and any_delta_o and irq_req_o are low.
- R8: any_delta_o is high exactly when at least one change flag is set. irq_req_o is any_delta_o gated by irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_cts_i | input | 1 | Clear-to-send line, asynchronous |
| line_dsr_i | input | 1 | Data-set-ready line, asynchronous |
| line_dcd_i | input | 1 | Carrier detect line, asynchronous |
| line_ri_i | input | 1 | Ring indicator line, asynchronous |
| ctl_dtr_i | input | 1 | Modem control dtr bit |
| ctl_rts_i | input | 1 | Modem control rts bit |
| ctl_out1_i | input | 1 | Modem control out1 bit |
| ctl_out2_i | input | 1 | Modem control out2 bit |
| ctl_loop_i | input | 1 | Modem control loopback bit |
| irq_en_i | input | 1 | Modem status interrupt enable |
| rd_stb_i | input | 1 | One-cycle read strobe for the register |
| rd_data_o | output | 8 | Register read data |
| any_delta_o | output | 1 | At least one change flag set |
| irq_req_o | output | 1 | Modem status interrupt request |

## Verification
A read that clears the flags and a line change that sets a flag can fall on the same clock edge. If the clear wins, an edge on the line is lost without a trace. The bench provokes this by changing carrier detect exactly two edges before it raises the read strobe, so the synchronized change reaches the register on the edge where the read ends. That read must return the earlier value. The next read must show the carrier-detect flag set and the earlier data-set-ready flag cleared.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NLINES  = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;
    localparam logic [NLINES-1:0] RESET_LVL = 4'b1011;

    typedef struct packed {
        logic [NLINES-1:0] lvl;
        logic [NLINES-1:0] dlt;
    } msr_reg_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int              STAGES  = 2,
    parameter int              WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/msr_track.sv
module msr_track
    import msr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lvl_i,
    input  logic              clr_i,
    output msr_reg_t          reg_o
);
    msr_reg_t          reg_d, reg_q;
    logic [NLINES-1:0] set_mask;

    always_comb begin
        set_mask         = lvl_i ^ reg_q.lvl;
        set_mask[IDX_RI] = reg_q.lvl[IDX_RI] & ~lvl_i[IDX_RI];
        reg_d.lvl        = lvl_i;
        reg_d.dlt        = (clr_i ? '0 : reg_q.dlt) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.lvl <= RESET_LVL;
            reg_q.dlt <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign reg_o = reg_q;

    for (genvar i = 0; i < NLINES; i++) begin : g_chk
        // R2: a flag holds until a clear
        a_r2_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_q.dlt[i] && !clr_i) |=> reg_q.dlt[i]);
    end

    // R2: a level change on a non-ring line raises its flag
    a_r2_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i[IDX_CTS] != reg_q.lvl[IDX_CTS]) |=> reg_q.dlt[IDX_CTS]);

    // R3: a rising ring indicator leaves the ring flag as it was
    a_r3_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q.lvl[IDX_RI] && lvl_i[IDX_RI] && !reg_q.dlt[IDX_RI]) |=> !reg_q.dlt[IDX_RI]);

    // R4: a clear with no change pending leaves all flags low
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (lvl_i == reg_q.lvl)) |=> (reg_q.dlt == '0));
endmodule

// File: rtl/msr_rdmux.sv
module msr_rdmux
    import msr_pkg::*;
(
    input  msr_reg_t   reg_i,
    input  logic       loop_i,
    input  logic       dtr_i,
    input  logic       rts_i,
    input  logic       out1_i,
    input  logic       out2_i,
    output logic [7:0] data_o
);
    always_comb begin
        if (loop_i) data_o = {out2_i, out1_i, dtr_i, rts_i, 4'b0000};
        else        data_o = reg_i;
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_cts_i,
    input  logic       line_dsr_i,
    input  logic       line_dcd_i,
    input  logic       line_ri_i,
    input  logic       ctl_dtr_i,
    input  logic       ctl_rts_i,
    input  logic       ctl_out1_i,
    input  logic       ctl_out2_i,
    input  logic       ctl_loop_i,
    input  logic       irq_en_i,
    input  logic       rd_stb_i,
    output logic [7:0] rd_data_o,
    output logic       any_delta_o,
    output logic       irq_req_o
);
    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] sync_lines;
    logic              clr_flags;
    msr_reg_t          stat;

    assign raw_lines = {line_dcd_i, line_ri_i, line_dsr_i, line_cts_i};
    assign clr_flags = rd_stb_i & ~ctl_loop_i;

    msr_sync #(.STAGES(SYNC_STAGES), .WIDTH(NLINES), .RST_VAL(RESET_LVL)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_lines), .sync_o(sync_lines));

    msr_track u_track (
        .clk(clk), .rst_n(rst_n), .lvl_i(sync_lines), .clr_i(clr_flags), .reg_o(stat));

    msr_rdmux u_rdmux (
        .reg_i(stat), .loop_i(ctl_loop_i), .dtr_i(ctl_dtr_i), .rts_i(ctl_rts_i),
        .out1_i(ctl_out1_i), .out2_i(ctl_out2_i), .data_o(rd_data_o));

    assign any_delta_o = |stat.dlt;
    assign irq_req_o   = any_delta_o & irq_en_i;

    // R6: a loopback read keeps pending flags
    a_r6_loop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && ctl_loop_i && any_delta_o) |=> any_delta_o);

    // R8: no request while the enable is low
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> irq_en_i);
endmodule

// File: tb/modem_status_unit_tb_top.sv
module modem_status_unit_tb_top;
    logic clk = 0, rst_n = 0;
    logic cts = 1, dsr = 1, dcd = 1, ri = 0;
    logic dtr = 0, rts = 0, out1 = 0, out2 = 0, lp = 0, ien = 0, rd = 0;
    logic [7:0] rdata;
    logic any_d, irq;
    int n_run = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    modem_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .line_cts_i(cts), .line_dsr_i(dsr),
        .line_dcd_i(dcd), .line_ri_i(ri), .ctl_dtr_i(dtr), .ctl_rts_i(rts),
        .ctl_out1_i(out1), .ctl_out2_i(out2), .ctl_loop_i(lp), .irq_en_i(ien),
        .rd_stb_i(rd), .rd_data_o(rdata), .any_delta_o(any_d), .irq_req_o(irq));

    // monitor: pops expected read values as reads happen
    always @(negedge clk) begin
        if (rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s read: got %02h expected %02h", t, rdata, e);
            end
        end
    end

    task automatic rd_expect(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd = 1;
        @(posedge clk); #1;
        rd = 0;
        @(posedge clk); #1;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic got, input logic e, input string t);
        n_run++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", t, got, e);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        settle();
        // R7 reset state
        chk(any_d, 1'b0, "R7 any_delta after reset");
        chk(irq, 1'b0, "R7 irq after reset");
        rd_expect(8'hB0, "R7 reset value");
        // R1/R2 cts drop, R8 any_delta without enable
        cts = 0; settle();
        chk(any_d, 1'b1, "R8 any_delta on cts change");
        chk(irq, 1'b0, "R8 irq masked");
        rd_expect(8'hA1, "R1 cts delta");
        rd_expect(8'hA0, "R4 cleared after read");
        chk(any_d, 1'b0, "R8 any_delta after clear");
        // R2 latency: third edge after the change
        ien = 1;
        dsr = 0;
        repeat (2) @(posedge clk); #1;
        chk(any_d, 1'b0, "R2 not yet after two edges");
        @(posedge clk); #1;
        chk(any_d, 1'b1, "R2 visible after third edge");
        chk(irq, 1'b1, "R8 irq enabled");
        rd_expect(8'h82, "R1 dsr delta");
        chk(irq, 1'b0, "R8 irq after read");
        // R3 ring
        ri = 1; settle();
        chk(any_d, 1'b0, "R3 no flag on ring rise");
        rd_expect(8'hC0, "R3 ring rise");
        ri = 0; settle();
        rd_expect(8'h84, "R3 ring fall");
        // R2 sticky over a return to the old level
        dcd = 0; settle();
        repeat (20) @(posedge clk);
        dcd = 1; settle();
        rd_expect(8'h88, "R2 dcd sticky");
        // two lines at once
        cts = 1; dsr = 1; settle();
        rd_expect(8'hB3, "R2 two flags");
        rd_expect(8'hB0, "R4 cleared");
        // R5/R6 loopback
        cts = 0; settle();
        lp = 1; dtr = 1; rts = 0; out1 = 1; out2 = 0; #1;
        rd_expect(8'h60, "R5 loop map");
        dtr = 1; rts = 1; out1 = 1; out2 = 1; #1;
        rd_expect(8'hF0, "R5 loop all ones");
        chk(any_d, 1'b1, "R6 flag kept in loopback");
        lp = 0; #1;
        rd_expect(8'hA1, "R6 flag kept after loopback");
        rd_expect(8'hA0, "R4 cleared after loopback");
        // R4 collision: read edge equals change edge
        dsr = 0; settle();
        dcd = 0;
        repeat (2) @(posedge clk); #1;
        rd_expect(8'h82, "R4 collision read");
        rd_expect(8'h08, "R4 change survives clear");
        rd_expect(8'h00, "R4 final clear");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule